// File: doc/BRIEF.md
# Widening Vector Shift-Left Unit

This block executes one vector instruction: a left shift that doubles the element width. It decodes a 32-bit instruction word and takes the low or the high 64-bit half of a 128-bit source vector. Each element in that half is widened to twice its width, and the shift amount is always the element's own width. The 128-bit result appears together with the register indices taken from the instruction word.

An execution pipeline uses it by presenting an instruction word, the value of the source register and a valid strobe. One clock later the unit returns the result, the destination and source register indices, and a flag. The flag shows either that the instruction was executed or that it had the reserved size encoding. Any other instruction word, and any cycle without the strobe, leaves every output at zero.

Top module: `widen_shl_unit`

## Requirements
- R1: An instruction word matches only when bit 31 is 0, bits 29:24 equal 101110 and bits 21:10 equal 100001001110; any other word with the strobe high leaves every output at zero in the following cycle.
- R2: Bit 30 selects the source half. 0 takes source bits 63:0 and 1 takes source bits 127:64.
- R3: Bits 23:22 form the size code. Codes 00, 01 and 10 give source elements of 8, 16 and 32 bits, and so 8, 4 and 2 elements in the 64-bit half.
- R4: Destination element e, twice the source width, holds source element e of the selected half shifted left by the source width and truncated to the destination width, for every e.
- R5: A matching word with size code 11 raises `res_undef` for one cycle with `res_valid` low and `res_data` zero.
- R6: The source register index is word bits 9:5 and the destination index is word bits 4:0. Both are presented with either flag and are zero otherwise.
- R7: Results, flags and indices appear exactly one clock after the input cycle. With the strobe low, the next cycle's outputs are all zero.
- R8: While reset is high and in the cycle after it, all outputs are zero.
- R9: In a valid result, the lower half of every destination element is zero, and the result is the same whether elements are taken as signed or unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction presented this cycle |
| op_word | input | 32 | Instruction word |
| op_src | input | 128 | Source register value |
| res_valid | output | 1 | Recognised instruction, result valid |
| res_undef | output | 1 | Recognised pattern with reserved size code |
| res_dst_idx | output | 5 | Destination register index |
| res_src_idx | output | 5 | Source register index |
| res_data | output | 128 | Widened, shifted result |

## Verification
Every output comes from a single register stage, so each flag, index and data value is due exactly one rising edge after the cycle in which it was presented. The bench computes the expected values at that same edge from the inputs it drove, using a behavioural model. It compares them at the following falling edge, before the next stimulus is applied. Because the check happens at that edge, a result that arrives a cycle early or late fails the check. A flag left high from the previous stimulus also fails.

// File: rtl/wsl_pkg.sv
package wsl_pkg;

    localparam int WORD_W  = 32;
    localparam int VEC_W   = 128;
    localparam int HALF_W  = VEC_W / 2;
    localparam int IDX_W   = 5;
    localparam int BASE_EW = 8;
    localparam int NUM_SZ  = 3;

    localparam logic [5:0]  PAT_MID = 6'b101110;
    localparam logic [11:0] PAT_LOW = 12'b100001001110;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } elem_sz_e;

    typedef struct packed {
        logic             match;
        logic             rsvd;
        logic             upper;
        elem_sz_e         sz;
        logic [IDX_W-1:0] src_idx;
        logic [IDX_W-1:0] dst_idx;
    } dec_t;

    typedef struct packed {
        logic             ok;
        logic             undef;
        logic [IDX_W-1:0] dst_idx;
        logic [IDX_W-1:0] src_idx;
        logic [VEC_W-1:0] data;
    } res_t;

    function automatic int elem_width(input int code);
        return BASE_EW << code;
    endfunction

    function automatic logic [VEC_W-1:0] low_zero_mask(input logic [1:0] code);
        logic [VEC_W-1:0] m;
        int ew;
        m  = '0;
        ew = BASE_EW << code;
        for (int b = 0; b < VEC_W; b++) begin
            if ((b % (2 * ew)) < ew) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/wsl_decode.sv
module wsl_decode
    import wsl_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    logic top_ok, mid_ok, low_ok;

    always_comb begin
        top_ok      = (word[31] == 1'b0);
        mid_ok      = (word[29:24] == PAT_MID);
        low_ok      = (word[21:10] == PAT_LOW);
        dec.match   = top_ok && mid_ok && low_ok;
        dec.sz      = elem_sz_e'(word[23:22]);
        dec.rsvd    = (dec.sz == SZ_RSVD);
        dec.upper   = word[30];
        dec.src_idx = word[9:5];
        dec.dst_idx = word[4:0];
    end
endmodule

// File: rtl/wsl_half_sel.sv
module wsl_half_sel
    import wsl_pkg::*;
(
    input  logic [VEC_W-1:0]  src,
    input  logic              upper,
    output logic [HALF_W-1:0] half
);
    always_comb begin
        if (upper) half = src[VEC_W-1:HALF_W];
        else       half = src[HALF_W-1:0];
    end
endmodule

// File: rtl/wsl_widen_lane.sv
module wsl_widen_lane #(
    parameter int HALF_BITS = 64,
    parameter int ESIZE     = 8
) (
    input  logic [HALF_BITS-1:0]   half,
    output logic [2*HALF_BITS-1:0] wide
);
    localparam int NELEM = HALF_BITS / ESIZE;
    localparam int DSIZE = 2 * ESIZE;

    for (genvar e = 0; e < NELEM; e++) begin : g_elem
        assign wide[e*DSIZE +: DSIZE] = {half[e*ESIZE +: ESIZE], {ESIZE{1'b0}}};
    end
endmodule

// File: rtl/wsl_out_reg.sv
module wsl_out_reg
    import wsl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  res_t nxt,
    output res_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/widen_shl_unit.sv
module widen_shl_unit
    import wsl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [WORD_W-1:0]  op_word,
    input  logic [VEC_W-1:0]   op_src,
    output logic               res_valid,
    output logic               res_undef,
    output logic [IDX_W-1:0]   res_dst_idx,
    output logic [IDX_W-1:0]   res_src_idx,
    output logic [VEC_W-1:0]   res_data
);
    dec_t               dec;
    logic [HALF_W-1:0]  half;
    logic [VEC_W-1:0]   wide [NUM_SZ];
    logic [VEC_W-1:0]   picked;
    res_t               nxt, cur;

    wsl_decode u_dec (
        .word (op_word),
        .dec  (dec)
    );

    wsl_half_sel u_half (
        .src   (op_src),
        .upper (dec.upper),
        .half  (half)
    );

    for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
        wsl_widen_lane #(
            .HALF_BITS (HALF_W),
            .ESIZE     (elem_width(s))
        ) u_lane (
            .half (half),
            .wide (wide[s])
        );
    end

    always_comb begin
        unique case (dec.sz)
            SZ_BYTE: picked = wide[0];
            SZ_HALF: picked = wide[1];
            SZ_WORD: picked = wide[2];
            default: picked = '0;
        endcase
    end

    always_comb begin
        nxt = '0;
        if (op_valid && dec.match) begin
            nxt.dst_idx = dec.dst_idx;
            nxt.src_idx = dec.src_idx;
            if (dec.rsvd) begin
                nxt.undef = 1'b1;
            end else begin
                nxt.ok   = 1'b1;
                nxt.data = picked;
            end
        end
    end

    wsl_out_reg u_oreg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    assign res_valid   = cur.ok;
    assign res_undef   = cur.undef;
    assign res_dst_idx = cur.dst_idx;
    assign res_src_idx = cur.src_idx;
    assign res_data    = cur.data;
endmodule

// File: rtl/wsl_checker.sv
module wsl_checker
    import wsl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [WORD_W-1:0] op_word,
    input logic              res_valid,
    input logic              res_undef,
    input logic [IDX_W-1:0]  res_dst_idx,
    input logic [IDX_W-1:0]  res_src_idx,
    input logic [VEC_W-1:0]  res_data
);
    // R5: the reserved size never yields data or a valid flag
    a_r5_undef_alone: assert property (@(posedge clk) disable iff (rst)
        res_undef |-> (!res_valid && res_data == '0));

    // R7: without a strobe the next cycle is quiet
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && !res_undef && res_data == '0));

    // R1: a non-matching word produces nothing
    a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (rst)
        (op_word[31] || op_word[29:24] != PAT_MID || op_word[21:10] != PAT_LOW)
        |=> (!res_valid && !res_undef));

    // R9: lower half of each widened element is zero
    a_r9_low_zero: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_data & low_zero_mask($past(op_word[23:22]))) == '0));

    // R6: indices follow the word fields from the previous cycle
    a_r6_idx_fields: assert property (@(posedge clk) disable iff (rst)
        (res_valid || res_undef) |->
        (res_dst_idx == $past(op_word[4:0]) && res_src_idx == $past(op_word[9:5])));

    // R3: a valid result never comes from the reserved code
    a_r3_legal_size: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(op_word[23:22]) != 2'b11));
endmodule

bind widen_shl_unit wsl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_word     (op_word),
    .res_valid   (res_valid),
    .res_undef   (res_undef),
    .res_dst_idx (res_dst_idx),
    .res_src_idx (res_src_idx),
    .res_data    (res_data)
);

// File: tb/tb_widen_shl_unit.sv
`timescale 1ns/1ps
module tb_widen_shl_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [31:0]  op_word;
    logic [127:0] op_src;
    logic         res_valid, res_undef;
    logic [4:0]   res_dst_idx, res_src_idx;
    logic [127:0] res_data;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    logic         e_valid, e_undef;
    logic [4:0]   e_dst, e_src;
    logic [127:0] e_data;
    bit           cmp_en = 0;

    always #2 clk = ~clk;

    widen_shl_unit dut (
        .clk (clk), .rst (rst), .op_valid (op_valid), .op_word (op_word),
        .op_src (op_src), .res_valid (res_valid), .res_undef (res_undef),
        .res_dst_idx (res_dst_idx), .res_src_idx (res_src_idx), .res_data (res_data)
    );

    function automatic logic [31:0] mk(input bit q, input logic [1:0] sz,
                                       input logic [4:0] rn, input logic [4:0] rd);
        return {1'b0, q, 6'b101110, sz, 12'b100001001110, rn, rd};
    endfunction

    function automatic logic [127:0] model(input logic [31:0] w, input logic [127:0] s);
        logic [127:0] r, elem, mask;
        int ew, cnt, base;
        r    = '0;
        ew   = 8 << w[23:22];
        cnt  = 64 / ew;
        base = w[30] ? 64 : 0;
        mask = (128'd1 << ew) - 128'd1;
        for (int e = 0; e < cnt; e++) begin
            elem = (s >> (base + e * ew)) & mask;
            r    = r | ((elem << ew) << (e * 2 * ew));
        end
        return r;
    endfunction

    // reference model: expected outputs for the edge just taken
    always @(posedge clk) begin
        bit m;
        m = !op_word[31] && op_word[29:24] == 6'b101110 && op_word[21:10] == 12'b100001001110;
        if (rst || !op_valid || !m) begin
            e_valid <= 0; e_undef <= 0; e_dst <= 0; e_src <= 0; e_data <= 0;
        end else begin
            e_dst <= op_word[4:0];
            e_src <= op_word[9:5];
            if (op_word[23:22] == 2'b11) begin
                e_valid <= 0; e_undef <= 1; e_data <= 0;
            end else begin
                e_valid <= 1; e_undef <= 0; e_data <= model(op_word, op_src);
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R7/R1 valid flag", 128'(res_valid), 128'(e_valid));
            chk("R5 undef flag",    128'(res_undef), 128'(e_undef));
            chk("R6 dst index",     128'(res_dst_idx), 128'(e_dst));
            chk("R6 src index",     128'(res_src_idx), 128'(e_src));
            chk("R4/R2/R3 data",    res_data, e_data);
        end
    end

    task automatic drive(input bit v, input logic [31:0] w, input logic [127:0] s);
        @(negedge clk);
        op_valid = v; op_word = w; op_src = s;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; op_valid = 1; op_src = {128{1'b1}};
        op_word = mk(1'b0, 2'b00, 5'd3, 5'd4);
        repeat (3) @(negedge clk);
        // R8: outputs zero under reset even with a matching word
        chk("R8 reset valid", 128'(res_valid), 128'd0);
        chk("R8 reset undef", 128'(res_undef), 128'd0);
        chk("R8 reset data",  res_data, 128'd0);
        rst = 0; op_valid = 0;
        @(negedge clk);
        chk("R8 post-reset valid", 128'(res_valid), 128'd0);
        cmp_en = 1;

        // R2/R4: known pattern, byte elements, both halves
        drive(1, mk(0, 2'b00, 5'd1, 5'd2), 128'hF0E1D2C3B4A59687_8877665544332211);
        drive(1, mk(1, 2'b00, 5'd1, 5'd2), 128'hF0E1D2C3B4A59687_8877665544332211);
        // R9: negative-looking elements must not sign extend
        drive(1, mk(0, 2'b01, 5'd7, 5'd8), {64'h0, 64'hFFFF_8000_7FFF_0001});
        drive(1, mk(1, 2'b10, 5'd31, 5'd0), {64'h8000_0000_FFFF_FFFF, 64'h0});

        // R3/R4/R2: random data, all legal sizes, both halves
        for (int i = 0; i < 300; i++) begin
            drive(1, mk(i[0], 2'(i % 3), 5'($urandom()), 5'($urandom())), rnd128());
        end

        // R5: reserved size, both halves
        drive(1, mk(0, 2'b11, 5'd9, 5'd10), rnd128());
        drive(1, mk(1, 2'b11, 5'd11, 5'd12), rnd128());

        // R7: strobe low with a matching word
        drive(0, mk(0, 2'b00, 5'd1, 5'd1), rnd128());
        // back-to-back after idle
        drive(1, mk(1, 2'b01, 5'd5, 5'd6), rnd128());

        // R1: single-bit corruption of each fixed pattern bit
        for (int b = 10; b < 32; b++) begin
            if (b == 22 || b == 23 || b == 30) continue;
            drive(1, mk(0, 2'b00, 5'd2, 5'd3) ^ (32'd1 << b), rnd128());
        end
        // R1: random words
        for (int i = 0; i < 100; i++) drive(1, $urandom(), rnd128());

        drive(0, 32'd0, 128'd0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule